// File: doc/BRIEF.md
# Request-Gated Block Replayer

This block holds one block of sample words in a small local buffer and plays it out to a downstream consumer a programmed number of times. Software or upstream logic first fills the buffer through a simple write port while the block is idle. It then strobes an arm input together with a 4-bit pass count.

With a count of one, the single pass starts immediately. With a larger count, the block waits before every pass for a one-cycle request pulse from the consumer. Each pass emits the whole block, oldest address first, as one word per clock with a valid flag held high throughout. After the final pass the block pulses a done flag and returns to idle. A count of zero finishes at once with only the done pulse.

The block length is a parameter, 16 words by default. The data path is 24 bits wide.

Top module: `pass_replayer`

## Requirements
- R1: While reset is high, and on the first clock after it, `out_valid` and `done` are 0 and `out_data` is all zeros. Reset is synchronous and active high.
- R2: After an arm with a count N of 2 or more, no word is emitted until a request is sampled. A request sampled at clock edge e gives `out_valid` high from edge e+1, one edge later.
- R3: Every pass emits exactly BLOCK_LEN consecutive words with no gap, carrying buffer addresses 0, 1, … BLOCK_LEN-1 in that order. Whenever `out_valid` is 0, `out_data` is zero.
- R4: An arm with N = 1 starts its pass without any request. The first word appears one clock edge after the arm is sampled.
- R5: A request pulse that arrives while a pass is streaming is ignored. It neither lengthens that pass nor starts another one.
- R6: A request pulse that arrives while the block is idle produces no output.
- R7: For N ≥ 1, `done` is high for exactly one cycle, together with the last word of the N-th pass. Requests after that produce no output.
- R8: An arm with N = 0 produces no word, and `done` is high on the cycle after the arm is sampled.
- R9: Writes to the buffer take effect only while the block is idle. A write while armed, whether waiting or streaming, leaves the buffer unchanged.
- R10: An arm strobe while the block is already armed is ignored, so the remaining pass count stays as it was.
- R11: The largest count, N = 15, yields exactly 15 passes.
- R12: A reset in the middle of a pass drops `out_valid` on the next cycle and clears the remaining pass count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe that loads `pass_count` and starts a run |
| pass_count | input | 4 | Number of passes to play |
| req | input | 1 | One-cycle request pulse from the consumer |
| wr_en | input | 1 | Buffer write enable (honoured only while idle) |
| wr_addr | input | 4 | Buffer write address (AW bits, 4 at default length) |
| wr_data | input | 24 | Buffer write data |
| out_valid | output | 1 | High while a pass is streaming |
| out_data | output | 24 | Streamed word, zero when not valid |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The main function is driven from a table of runs with pass counts 2, 3, 1 and 15, each over a different buffer pattern. Comparing the runs shows that the number of passes follows the count, and that the data follows the buffer contents rather than some fixed sequence. The N = 1 run, compared with the others, shows the difference between streaming at once and waiting for a request; the exact latency is checked in both cases. The 15-pass run exercises the full counter range.

Directed tests then inject requests while idle, while streaming and after completion. They also apply writes and a second arm while the block is waiting, a zero count, and a reset in the middle of a pass. Each of these should leave the output stream either unchanged or silent.

// File: rtl/replay_pkg.sv
package replay_pkg;

    localparam int DATA_W = 24;
    localparam int CNT_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_STREAM = 2'd2
    } seq_state_e;

    // Register set of the sequencer, carried as one struct.
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] left;
        logic             valid;
        logic             done;
    } seq_regs_t;

    function automatic logic [CNT_W-1:0] one_less(input logic [CNT_W-1:0] v);
        return v - 1'b1;
    endfunction

endpackage

// File: rtl/replay_buffer.sv
module replay_buffer #(
    parameter int DATA_W = replay_pkg::DATA_W,
    parameter int DEPTH  = 16,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Registered read, forced to zero outside a pass.
    always_ff @(posedge clk) begin
        if (rst || !rd_en) begin
            rd_data <= '0;
        end else begin
            rd_data <= store[rd_addr];
        end
    end

endmodule

// File: rtl/replay_seq.sv
module replay_seq
    import replay_pkg::*;
#(
    parameter int CNT_W     = replay_pkg::CNT_W,
    parameter int BLOCK_LEN = 16,
    parameter int AW        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] pass_cnt_i,
    input  logic             req_i,
    output logic             idle_o,
    output logic             rd_en_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam logic [AW-1:0] LAST = AW'(BLOCK_LEN - 1);

    seq_regs_t     r_q, r_d;
    logic [AW-1:0] addr_q, addr_d;

    always_comb begin
        r_d       = r_q;
        addr_d    = addr_q;
        r_d.done  = 1'b0;
        r_d.valid = (r_q.state == ST_STREAM);
        unique case (r_q.state)
            ST_IDLE: begin
                if (arm_i) begin
                    r_d.left = pass_cnt_i;
                    addr_d   = '0;
                    if (pass_cnt_i == '0) begin
                        r_d.done = 1'b1;
                    end else if (pass_cnt_i == CNT_W'(1)) begin
                        r_d.state = ST_STREAM;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (req_i) begin
                    r_d.state = ST_STREAM;
                    addr_d    = '0;
                end
            end
            ST_STREAM: begin
                if (addr_q == LAST) begin
                    addr_d   = '0;
                    r_d.left = one_less(r_q.left);
                    if (r_q.left == CNT_W'(1)) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end else begin
                    addr_d = addr_q + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q    <= '{state: ST_IDLE, left: '0, valid: 1'b0, done: 1'b0};
            addr_q <= '0;
        end else begin
            r_q    <= r_d;
            addr_q <= addr_d;
        end
    end

    assign idle_o    = (r_q.state == ST_IDLE);
    assign rd_en_o   = (r_q.state == ST_STREAM);
    assign rd_addr_o = addr_q;
    assign valid_o   = r_q.valid;
    assign done_o    = r_q.done;

    // R2: a waiting sequencer never starts a pass without a request
    a_r2_wait_needs_req: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_WAIT && !req_i) |=> (r_q.state != ST_STREAM));

    // R3: a pass in progress advances one address per clock
    a_r3_no_gap: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_STREAM && addr_q != LAST)
        |=> (r_q.state == ST_STREAM && addr_q == AW'($past(addr_q) + 1'b1)));

    // R5: the remaining count holds steady mid-pass whatever req does
    a_r5_count_steady: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_STREAM && addr_q != LAST) |=> $stable(r_q.left));

    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: zero count finishes at once without streaming
    a_r8_zero_count: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_IDLE && arm_i && pass_cnt_i == '0)
        |=> (done_o && r_q.state == ST_IDLE));

    // R10: arm while armed does not reload the count
    a_r10_arm_busy: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_WAIT && arm_i && !req_i) |=> $stable(r_q.left));

endmodule

// File: rtl/pass_replayer.sv
module pass_replayer #(
    parameter int DATA_W    = replay_pkg::DATA_W,
    parameter int CNT_W     = replay_pkg::CNT_W,
    parameter int BLOCK_LEN = 16,
    localparam int AW       = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic [CNT_W-1:0]  pass_count,
    input  logic              req,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              done
);

    logic          idle;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          wr_take;

    assign wr_take = wr_en && idle;

    replay_seq #(
        .CNT_W    (CNT_W),
        .BLOCK_LEN(BLOCK_LEN),
        .AW       (AW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (arm),
        .pass_cnt_i(pass_count),
        .req_i     (req),
        .idle_o    (idle),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr),
        .valid_o   (out_valid),
        .done_o    (done)
    );

    replay_buffer #(
        .DATA_W(DATA_W),
        .DEPTH (BLOCK_LEN),
        .AW    (AW)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_take),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(out_data)
    );

    // R1, R12: reset silences the outputs on the following cycle
    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_valid && !done && out_data == '0));

    // R3: data is zero whenever valid is low
    a_r3_zero_idle_data: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

endmodule

// File: tb/pass_replayer_tb.sv
module pass_replayer_tb;

    localparam int L  = 16;
    localparam int AW = 4;
    localparam int DW = 24;

    // Each entry: pass count in [27:24], pattern seed in [23:0]
    localparam logic [3:0][27:0] VEC = {
        {4'd15, 24'h0F0F00},
        {4'd1,  24'h777000},
        {4'd3,  24'hA50000},
        {4'd2,  24'h100000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          arm = 1'b0;
    logic [3:0]    pass_count = '0;
    logic          req = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          done;

    logic [DW-1:0] exp_mem [L];
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    pass_replayer #(.BLOCK_LEN(L)) u_dut (
        .clk(clk), .rst(rst), .arm(arm), .pass_count(pass_count), .req(req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [DW-1:0] seed);
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = seed + DW'(i * 24'h010307);
            exp_mem[i] = wr_data;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_arm(input logic [3:0] n);
        @(negedge clk);
        arm = 1'b1;
        pass_count = n;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Expects one pass to begin at the next negedge.
    task automatic expect_pass(input string tag, input bit last, input bit mid_req);
        int errs_before;
        errs_before = errors;
        @(negedge clk);
        chk(out_valid === 1'b1, {tag, " start latency"}, 32'(out_valid), 32'h1);
        for (int i = 0; i < L; i++) begin
            if (i > 0) @(negedge clk);
            if (mid_req && i == L/2 + 1) req = 1'b0;
            if (!(out_valid === 1'b1 && out_data === exp_mem[i])) begin
                chk(1'b0, {tag, " word"}, {7'd0, out_valid, out_data}, {8'h01, exp_mem[i]});
            end
            if (done !== ((i == L-1) ? last : 1'b0)) begin
                chk(1'b0, {tag, " done timing"}, 32'(done), 32'((i == L-1) ? last : 1'b0));
            end
            if (mid_req && i == L/2) req = 1'b1;
        end
        chk(errors == errs_before, {tag, " pass words"}, 32'(errors - errs_before), 32'h0);
        @(negedge clk);
        chk(out_valid === 1'b0 && out_data === '0, {tag, " end of pass"},
            {7'd0, out_valid, out_data}, 32'h0);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        int seen;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (out_valid !== 1'b0 || done !== 1'b0) seen++;
        end
        chk(seen == 0, tag, 32'(seen), 32'h0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && done === 1'b0 && out_data === '0, "R1 reset outputs",
            {6'd0, out_valid, done, out_data}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && done === 1'b0, "R1 after reset", {30'd0, out_valid, done}, 32'h0);

        // Table of runs: R2, R3, R4, R7, R11
        for (int v = 0; v < 4; v++) begin
            logic [3:0] n;
            n = VEC[v][27:24];
            fill(VEC[v][23:0]);
            do_arm(n);
            if (n == 4'd1) begin
                expect_pass("R4 single pass immediate", 1'b1, 1'b0);
            end else begin
                expect_quiet(5, "R2 no output before request");
                for (int p = 0; p < int'(n); p++) begin
                    pulse_req();
                    expect_pass(n == 4'd15 ? "R11 max count pass" : "R2 R3 gated pass",
                                p == int'(n) - 1, 1'b0);
                end
            end
            pulse_req();
            expect_quiet(2*L, "R7 no pass after done");
        end

        // R6: request while idle
        pulse_req();
        expect_quiet(2*L, "R6 idle request ignored");

        // R8: zero count
        do_arm(4'd0);
        chk(done === 1'b1 && out_valid === 1'b0, "R8 zero count done", {30'd0, done, out_valid}, 32'h2);
        expect_quiet(L, "R8 nothing after zero count");

        // R9, R10: write and re-arm while waiting
        fill(24'h3C0000);
        do_arm(4'd2);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = '0; wr_data = 24'hDEAD00;
        @(negedge clk);
        wr_en = 1'b0;
        do_arm(4'd0);
        chk(done === 1'b0, "R10 re-arm ignored", 32'(done), 32'h0);
        pulse_req();
        expect_pass("R9 busy write dropped", 1'b0, 1'b0);
        pulse_req();
        expect_pass("R10 count kept", 1'b1, 1'b0);

        // R5: request during a pass
        do_arm(4'd2);
        pulse_req();
        expect_pass("R5 mid-pass request", 1'b0, 1'b1);
        expect_quiet(2*L, "R5 no extra pass");
        pulse_req();
        expect_pass("R5 final pass", 1'b1, 1'b0);

        // R12: reset mid-pass
        do_arm(4'd3);
        pulse_req();
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid === 1'b0 && done === 1'b0, "R12 reset drops valid", {30'd0, out_valid, done}, 32'h0);
        pulse_req();
        expect_quiet(2*L, "R12 count cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule